// File: doc/BRIEF.md
# Two-Level Direct-Mapped Data Cache Controller

This controller fronts a word-addressed memory with two data caches. The near cache (L1) is small and direct mapped. It is indexed and tagged by the virtual address, and every store passes through it to the far cache. The far cache (L2) is larger and direct mapped. It is indexed and tagged by the physical address, which an external translation stage supplies with each request. A control input chooses whether L2 holds stores as dirty lines (copy-back) or forwards every store to memory (write-through).

Each L2 line keeps a back-pointer: the L1 index that currently holds a copy of it. The controller uses this pointer in three cases. It invalidates a stale L1 copy when the same physical word is filled under another virtual index. It invalidates an L1 alias when a store misses L1 but hits L2. It invalidates the L1 copy when the L2 line is evicted. As a result, a physical word never has two live L1 copies, and L1 always holds a subset of L2. Lines are one word wide. The memory side is a single request/acknowledge word port.

Top module: `dual_level_cache`

## Requirements
- R1: After reset the block is ready, shows no response and no memory request, and the first read of any address is served from memory.
- R2: A read that hits L1 shows `rsp_valid` with its data in the cycle right after the accepting edge, and such reads can be accepted on consecutive clocks.
- R3: A read that misses L1 but hits L2 shows its response three cycles later than an L1 hit would.
- R4: After a store is accepted, `req_ready` is low in the following cycle, so stores enter at most once every two clocks.
- R5: A store that hits L1 updates L1, and every store updates L2. A store that misses L1 does not allocate in L1. A store that misses L2 goes to memory without allocating.
- R6: With `l2_copyback` = 0, every store produces exactly one memory write of that word.
- R7: With `l2_copyback` = 1, a store that hits L2 makes no memory write and marks the line dirty. A dirty victim is written to memory before the refill read of the new line is issued.
- R8: When a physical word is filled into L1 under a new virtual index, its old L1 copy is invalidated. A store through one alias is then seen by a read through the other alias, and no two valid L1 entries ever hold the same physical word.
- R9: A read that misses both levels fills L2 from memory and then fills L1, returning the memory word. The L1 index is vaddr[2:0] and the L2 index is paddr[4:0] with the default parameters.
- R10: `mem_req` stays high, with stable `mem_we`, `mem_addr` and `mem_wdata`, until the cycle in which `mem_ack` is seen.
- R11: Evicting an L2 line invalidates its L1 copy, so every valid L1 entry is also present in L2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l2_copyback | input | 1 | Software-set far-cache policy: 1 copy-back, 0 write-through |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when high with `req_valid` |
| req_write | input | 1 | 1 store, 0 load |
| req_vaddr | input | AW | Virtual word address |
| req_paddr | input | AW | Translated physical word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle pulse carrying load data |
| rsp_rdata | output | DW | Load data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The embedded assertions watch, on every clock, four properties: the store spacing, the next-cycle response after an L1 hit, the three-cycle-later response after an L2 hit, and the memory handshake hold. They also watch three invariants: no duplicate physical word across valid L1 entries, L1 contained in L2, and no dirty line left in place while its refill is in flight. Some effects appear only over a sequence of operations, so only the bench's scenarios can show them. These are: a store through one alias becoming visible through the other, a write miss leaving L1 unallocated, a dirty victim reaching memory ahead of the refill read, and an eviction forcing the next read of a formerly cached word back to memory.

// File: rtl/dual_level_cache.sv
module dual_level_cache #(
  parameter int DW       = 32,
  parameter int AW       = 12,
  parameter int L1_IDX_W = 3,
  parameter int L2_IDX_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l2_copyback,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] req_paddr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int L1_N     = 1 << L1_IDX_W;
  localparam int L2_N     = 1 << L2_IDX_W;
  localparam int L1_TAG_W = AW - L1_IDX_W;
  localparam int L2_TAG_W = AW - L2_IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_L2, S_ALIAS, S_FILL, S_EVICT, S_REFILL, S_WR_L2, S_WR_MEM
  } st_t;
  st_t st;

  logic [L1_N-1:0]     l1_v;
  logic [L1_TAG_W-1:0] l1_tag [L1_N];
  logic [AW-1:0]       l1_pa  [L1_N];
  logic [DW-1:0]       l1_d   [L1_N];

  logic [L2_N-1:0]     l2_v, l2_dirty, l2_bpv;
  logic [L2_TAG_W-1:0] l2_tag [L2_N];
  logic [DW-1:0]       l2_d   [L2_N];
  logic [L1_IDX_W-1:0] l2_bp  [L2_N];

  logic          r_write, r_l1hit;
  logic [AW-1:0] r_va, r_pa;
  logic [DW-1:0] r_wd;

  wire [L1_IDX_W-1:0] in_vi  = req_vaddr[L1_IDX_W-1:0];
  wire                hit_in = l1_v[in_vi] && (l1_tag[in_vi] == req_vaddr[AW-1:L1_IDX_W]);
  wire                accept = req_valid && req_ready;

  wire [L1_IDX_W-1:0] vi    = r_va[L1_IDX_W-1:0];
  wire [L1_TAG_W-1:0] vt    = r_va[AW-1:L1_IDX_W];
  wire [L2_IDX_W-1:0] p_idx = r_pa[L2_IDX_W-1:0];
  wire [L2_TAG_W-1:0] p_tag = r_pa[AW-1:L2_IDX_W];

  wire                l2_hit   = l2_v[p_idx] && (l2_tag[p_idx] == p_tag);
  wire [L1_IDX_W-1:0] bp       = l2_bp[p_idx];
  wire [AW-1:0]       victim   = {l2_tag[p_idx], p_idx};
  wire                alias_ok = l2_bpv[p_idx] && l1_v[bp] && (l1_pa[bp] == r_pa);
  wire                vict_l1  = l2_bpv[p_idx] && l1_v[bp] && (l1_pa[bp] == victim);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_EVICT) || (st == S_REFILL) || (st == S_WR_MEM);
  assign mem_we    = (st == S_EVICT) || (st == S_WR_MEM);
  assign mem_addr  = (st == S_EVICT) ? victim : r_pa;
  assign mem_wdata = (st == S_EVICT) ? l2_d[p_idx] : r_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      l1_v      <= '0;
      l2_v      <= '0;
      l2_dirty  <= '0;
      l2_bpv    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      r_write   <= 1'b0;
      r_l1hit   <= 1'b0;
      r_va      <= '0;
      r_pa      <= '0;
      r_wd      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          r_write <= req_write;
          r_va    <= req_vaddr;
          r_pa    <= req_paddr;
          r_wd    <= req_wdata;
          r_l1hit <= hit_in;
          if (req_write) begin
            if (hit_in) l1_d[in_vi] <= req_wdata;
            st <= S_WR_L2;
          end else if (hit_in) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= l1_d[in_vi];
          end else begin
            st <= S_L2;
          end
        end
        S_L2: begin
          if (l2_hit) begin
            st <= S_ALIAS;
          end else begin
            if (l2_v[p_idx] && vict_l1) l1_v[bp] <= 1'b0;
            st <= (l2_v[p_idx] && l2_dirty[p_idx]) ? S_EVICT : S_REFILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          l2_dirty[p_idx] <= 1'b0;
          st              <= S_REFILL;
        end
        S_REFILL: if (mem_ack) begin
          l2_v[p_idx]     <= 1'b1;
          l2_tag[p_idx]   <= p_tag;
          l2_d[p_idx]     <= mem_rdata;
          l2_dirty[p_idx] <= 1'b0;
          l2_bpv[p_idx]   <= 1'b0;
          st              <= S_ALIAS;
        end
        S_ALIAS: begin
          if (alias_ok && (bp != vi)) l1_v[bp] <= 1'b0;
          st <= S_FILL;
        end
        S_FILL: begin
          l1_v[vi]      <= 1'b1;
          l1_tag[vi]    <= vt;
          l1_pa[vi]     <= r_pa;
          l1_d[vi]      <= l2_d[p_idx];
          l2_bp[p_idx]  <= vi;
          l2_bpv[p_idx] <= 1'b1;
          rsp_valid     <= 1'b1;
          rsp_rdata     <= l2_d[p_idx];
          st            <= S_IDLE;
        end
        S_WR_L2: begin
          if (l2_hit) begin
            l2_d[p_idx] <= r_wd;
            if (alias_ok && !r_l1hit) l1_v[bp] <= 1'b0;
            if (l2_copyback) begin
              l2_dirty[p_idx] <= 1'b1;
              st              <= S_IDLE;
            end else begin
              st <= S_WR_MEM;
            end
          end else begin
            st <= S_WR_MEM;
          end
        end
        S_WR_MEM: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic l1_dup, l1_orphan;
  always_comb begin
    l1_dup    = 1'b0;
    l1_orphan = 1'b0;
    for (int i = 0; i < L1_N; i++) begin
      for (int j = i + 1; j < L1_N; j++)
        if (l1_v[i] && l1_v[j] && (l1_pa[i] == l1_pa[j])) l1_dup = 1'b1;
      if (l1_v[i] && !(l2_v[l1_pa[i][L2_IDX_W-1:0]] &&
          (l2_tag[l1_pa[i][L2_IDX_W-1:0]] == l1_pa[i][AW-1:L2_IDX_W])))
        l1_orphan = 1'b1;
    end
  end

  AST_STORE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !req_ready); // R4
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit_in) |=> rsp_valid); // R2
  AST_L2_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_L2 && l2_hit) |-> ##3 rsp_valid); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R10
  AST_CLEAN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REFILL) |-> !(l2_v[p_idx] && l2_dirty[p_idx])); // R7
  AST_NO_DUP_PA: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_dup); // R8
  AST_L1_IN_L2: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_orphan); // R11
endmodule

// File: tb/tb_dual_level_cache.sv
module tb_dual_level_cache;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int LAT_ANY = -1;
  localparam int LAT_MEM = -2;

  logic          clk = 1'b0, rst_n = 1'b0, l2_copyback = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_vaddr = '0, req_paddr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, mem_req, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  dual_level_cache dut (
    .clk(clk), .rst_n(rst_n), .l2_copyback(l2_copyback),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_paddr(req_paddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, memwr = 0, memrd = 0, wait_cnt = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] refmem [logic [AW-1:0]];
  logic [DW-1:0] bmem   [logic [AW-1:0]];
  logic [AW-1:0] vmap   [logic [AW-1:0]];
  logic [AW:0]   oplog  [$];
  logic [DW-1:0] q_d [$];
  int            q_acc [$];
  int            q_lat [$];
  string         q_tag [$];

  function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
    return {20'hC0DE5, a};
  endfunction
  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return refmem.exists(a) ? refmem[a] : init_word(a);
  endfunction
  function automatic logic [DW-1:0] bm_rd(input logic [AW-1:0] a);
    return bmem.exists(a) ? bmem[a] : init_word(a);
  endfunction
  function automatic logic [AW-1:0] pa_of(input logic [AW-1:0] v);
    return vmap.exists(v) ? vmap[v] : v;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req) begin
      if (wait_cnt == 1) begin
        mem_ack <= 1'b1;
        oplog.push_back({mem_we, mem_addr});
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          memwr++;
        end else begin
          mem_rdata <= bm_rd(mem_addr);
          memrd++;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  logic          prev_pend = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend) chk(mem_req && mem_addr == prev_addr, "R10", "request held", mem_addr, prev_addr);
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
      if (rsp_valid) begin
        if (q_d.size() == 0) begin
          chk(1'b0, "R2", "unexpected response", rsp_rdata, 0);
        end else begin
          automatic logic [DW-1:0] ed = q_d.pop_front();
          automatic int acc = q_acc.pop_front();
          automatic int el  = q_lat.pop_front();
          automatic string tg = q_tag.pop_front();
          automatic int lat = cyc - acc;
          chk(rsp_rdata == ed, tg, "read data", rsp_rdata, ed);
          if (el >= 0)           chk(lat == el, tg, "latency", lat, el);
          else if (el == LAT_MEM) chk(lat > 3, tg, "memory latency", lat, 4);
        end
      end
    end
  end

  task automatic rd(input logic [AW-1:0] v, input int lat, input string tg);
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = v; req_paddr = pa_of(v);
    while (!req_ready) @(negedge clk);
    q_d.push_back(ref_rd(pa_of(v)));
    q_acc.push_back(cyc + 1);
    q_lat.push_back(lat);
    q_tag.push_back(tg);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] v, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = v; req_paddr = pa_of(v); req_wdata = d;
    while (!req_ready) @(negedge clk);
    refmem[pa_of(v)] = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R4", "ready after store", req_ready, 0);
  endtask

  task automatic settle();
    req_valid = 1'b0;
    while (!(req_ready && q_d.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
    chk(mem_req == 1'b0, "R1", "no memory request after reset", mem_req, 0);

    rd(12'h010, LAT_MEM, "R1"); settle();
    chk(memrd == 1, "R9", "one memory read for double miss", memrd, 1);
    rd(12'h010, 0, "R9");
    rd(12'h011, LAT_MEM, "R9");
    rd(12'h012, LAT_MEM, "R9"); settle();
    rd(12'h010, 0, "R2");
    rd(12'h011, 0, "R2");
    rd(12'h012, 0, "R2"); settle();

    rd(12'h018, LAT_MEM, "R9"); settle();
    rd(12'h010, 3, "R3"); settle();

    m = memwr;
    wr(12'h010, 32'h1111_0001); settle();
    chk(memwr == m + 1, "R6", "write-through store count", memwr, m + 1);
    chk(bm_rd(12'h010) == 32'h1111_0001, "R6", "memory word", bm_rd(12'h010), 32'h1111_0001);
    rd(12'h010, 0, "R5"); settle();

    rd(12'h019, LAT_MEM, "R9"); settle();
    wr(12'h011, 32'h2222_0002); settle();
    rd(12'h011, 3, "R5"); settle();

    vmap[12'h103] = 12'h040;
    vmap[12'h105] = 12'h040;
    rd(12'h103, LAT_MEM, "R8");
    rd(12'h105, 3, "R8");
    rd(12'h103, 3, "R8"); settle();
    wr(12'h105, 32'h3333_0003); settle();
    rd(12'h103, 3, "R8"); settle();

    vmap[12'h0AE] = 12'h232;
    rd(12'h0AE, LAT_MEM, "R11"); settle();
    rd(12'h012, LAT_MEM, "R11"); settle();

    l2_copyback = 1'b1;
    m = memwr;
    wr(12'h011, 32'h4444_0004); settle();
    chk(memwr == m, "R7", "no memory write on copy-back hit", memwr, m);
    chk(bm_rd(12'h011) == 32'h2222_0002, "R7", "memory keeps old word", bm_rd(12'h011), 32'h2222_0002);
    vmap[12'h0C7] = 12'h131;
    oplog.delete();
    rd(12'h0C7, LAT_MEM, "R7"); settle();
    chk(oplog.size() == 2, "R7", "memory operations on dirty eviction", oplog.size(), 2);
    if (oplog.size() == 2) begin
      chk(oplog[0] == {1'b1, 12'h011}, "R7", "victim write first", oplog[0], {1'b1, 12'h011});
      chk(oplog[1] == {1'b0, 12'h131}, "R7", "refill read second", oplog[1], {1'b0, 12'h131});
    end
    chk(bm_rd(12'h011) == 32'h4444_0004, "R7", "victim data in memory", bm_rd(12'h011), 32'h4444_0004);
    rd(12'h011, LAT_MEM, "R7"); settle();

    m = memwr;
    wr(12'h300, 32'h5555_0005); settle();
    chk(memwr == m + 1, "R5", "far-cache write miss goes to memory", memwr, m + 1);
    rd(12'h300, LAT_MEM, "R5"); settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule